// File: doc/BRIEF.md
# Streaming SPI Register Slave

This block is a mode-0 SPI target that fronts a small byte-wide register file inside a 15-bit address space. Every frame opens with a 16-bit header: a direction flag and then a 15-bit register address. After the header, the frame carries data bytes. While chip select stays low, each completed byte moves the internal address one register onward. A host can therefore write or read a run of neighbouring registers without sending a new header. Raising chip select ends the frame at any point.

Register 0 is the only register whose contents have a fixed meaning.
- Two mirrored bits choose whether the running address counts up or down.
- Two self-clearing mirrored bits return every other register to its default value.

All logic runs on the system clock. SCLK, CSB and MOSI pass through synchronizers and are edge-detected, so SCLK must be well below the system clock rate. Each SCLK phase must last at least four system clocks.

Top module: `spi_stream_regs`

## Requirements
- R1: A frame is CSB low, then 16 header bits sent MSB first: bit 15 is the direction flag (0 = write, 1 = read) and bits 14..0 are the address. With flag 0, the next 8 bits sent MSB first are stored in the addressed register when the eighth bit's rising SCLK edge is sampled.
- R2: With flag 1, SPI_MISO presents the addressed register MSB first. The first bit appears after the falling SCLK edge that follows the last address bit. Each later bit appears after the next falling edge.
- R3: CSB high ends the frame. The next CSB fall starts a fresh 16-bit header, so two accesses separated by CSB high are independent.
- R4: In a write frame, each further complete byte while CSB stays low goes to the next register in the current direction, with no new header and no limit on length.
- R5: In a read frame, after each 8 data bits the next register in the current direction is shifted out, for as long as CSB stays low.
- R6: The running address moves by +1 per byte when the ascend bit (register 0, bit 5) is 1 and by -1 when it is 0. The step after a byte uses the ascend value held before that byte is stored.
- R7: The running address wraps modulo 2^15: 0x7FFF plus one is 0x0000, and 0x0000 minus one is 0x7FFF.
- R8: If CSB rises before a data byte has 8 bits, that byte is discarded and no register changes.
- R9: A write to register 0 sets the ascend bit to the OR of data bits 5 and 2. Reading register 0 returns the ascend bit in both bit 5 and bit 2. Bits 6, 4, 3 and 1 read back as written.
- R10: Writing register 0 with bit 7 or bit 0 set returns all registers 1..NUM_REGS-1 to 0x00. Bits 7 and 0 always read back as 0.
- R11: Writes to addresses at or above NUM_REGS (default 32) are dropped, and reads from them return 0x00.
- R12: After reset every register holds 0x00, so the direction is descending. SPI_MISO is 0 whenever CSB is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_csb | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
SCLK, CSB and MOSI each pass two synchronizer stages and one edge-detect stage. A register update therefore lands about three system clocks after the SCLK rise that completes a byte. A new SPI_MISO bit settles about four clocks after a falling SCLK edge. The bench holds every SCLK phase for eight system clocks and samples SPI_MISO just before it raises SCLK, which leaves a margin of four clocks. Stored values are checked only by a later read frame, started after CSB has been high for sixteen clocks, so every write has settled before it is observed.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int SPI_ADDR_W = 15;
  localparam int SPI_DATA_W = 8;

  typedef enum logic {
    PH_HEADER = 1'b0,
    PH_DATA   = 1'b1
  } spi_phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csb_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csb_s,
  output logic mosi_s
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sclk_q;
  logic [STAGES-1:0] csb_q;
  logic [STAGES-1:0] mosi_q;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      csb_q  <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      csb_q  <= {csb_q[STAGES-2:0], csb_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      sclk_d <= sclk_q[LAST];
    end
  end

  assign sclk_rise = sclk_q[LAST] & ~sclk_d;
  assign sclk_fall = ~sclk_q[LAST] & sclk_d;
  assign csb_s     = csb_q[LAST];
  assign mosi_s    = mosi_q[LAST];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = SPI_ADDR_W,
  parameter int DATA_W = SPI_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csb_s,
  input  logic              mosi_s,
  input  logic              ascend,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              byte_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              miso
);
  localparam int HDR_BITS = ADDR_W + 1;
  localparam int CNT_W    = $clog2(HDR_BITS);

  spi_phase_e        phase_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [HDR_BITS-1:0] shift_q;
  logic [HDR_BITS-1:0] shift_nxt;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_step;
  logic [DATA_W-1:0] out_q;
  logic              miso_q;
  logic              hdr_done;

  assign shift_nxt = {shift_q[HDR_BITS-2:0], mosi_s};
  assign hdr_done  = sclk_rise && !csb_s && (phase_q == PH_HEADER) &&
                     (bitcnt_q == CNT_W'(HDR_BITS - 1));
  assign byte_done = sclk_rise && !csb_s && (phase_q == PH_DATA) &&
                     (bitcnt_q == CNT_W'(DATA_W - 1));

  // modular step: natural wrap of the ADDR_W-bit sum
  assign addr_step = ascend ? (addr_q + ADDR_W'(1)) : (addr_q - ADDR_W'(1));

  assign rd_addr  = hdr_done ? shift_nxt[ADDR_W-1:0] : addr_step;
  assign wr_en    = byte_done && !rw_q;
  assign wr_addr  = addr_q;
  assign wr_data  = shift_nxt[DATA_W-1:0];
  assign cur_addr = addr_q;
  assign miso     = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HEADER;
      bitcnt_q <= '0;
      shift_q  <= '0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      out_q    <= '0;
      miso_q   <= 1'b0;
    end else if (csb_s) begin
      phase_q  <= PH_HEADER;
      bitcnt_q <= '0;
      out_q    <= '0;
      miso_q   <= 1'b0;
    end else if (sclk_rise) begin
      shift_q <= shift_nxt;
      if (hdr_done) begin
        rw_q     <= shift_nxt[HDR_BITS-1];
        addr_q   <= shift_nxt[ADDR_W-1:0];
        phase_q  <= PH_DATA;
        bitcnt_q <= '0;
        out_q    <= shift_nxt[HDR_BITS-1] ? rd_data : '0;
      end else if (byte_done) begin
        addr_q   <= addr_step;
        bitcnt_q <= '0;
        out_q    <= rw_q ? rd_data : '0;
      end else begin
        bitcnt_q <= bitcnt_q + CNT_W'(1);
      end
    end else if (sclk_fall && (phase_q == PH_DATA)) begin
      miso_q <= out_q[DATA_W-1];
      out_q  <= {out_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       ascend,
  output logic [NUM_REGS*DATA_W-1:0] reg_image
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic              wr_hit;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              soft_clr;
  logic              ctrl_wr;
  logic              asc_new;

  assign wr_hit   = wr_en && (wr_addr < ADDR_W'(NUM_REGS));
  assign wr_idx   = wr_addr[IDX_W-1:0];
  assign ctrl_wr  = wr_hit && (wr_idx == '0);
  assign soft_clr = ctrl_wr && (wr_data[7] || wr_data[0]);
  assign asc_new  = wr_data[5] | wr_data[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= {1'b0, wr_data[6], asc_new, wr_data[4], wr_data[3],
                 asc_new, wr_data[1], 1'b0};
    end
  end

  assign ctrl_view = ctrl_q;
  assign mem_q[0]  = ctrl_view;
  assign ascend    = ctrl_q[5];

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (soft_clr) begin
        mem_q[g] <= '0;
      end else if (wr_hit && (wr_idx == IDX_W'(g))) begin
        mem_q[g] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_img
    assign reg_image[g*DATA_W +: DATA_W] = mem_q[g];
  end

  assign rd_idx  = rd_addr[IDX_W-1:0];
  assign rd_data = (rd_addr < ADDR_W'(NUM_REGS)) ? mem_q[rd_idx] : '0;
endmodule

// File: rtl/spi_stream_regs.sv
module spi_stream_regs
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int ADDR_W      = SPI_ADDR_W,
  parameter int DATA_W      = SPI_DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_csb,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic                       sclk_rise;
  logic                       sclk_fall;
  logic                       csb_s;
  logic                       mosi_s;
  logic                       ascend;
  logic [DATA_W-1:0]          rd_data;
  logic [ADDR_W-1:0]          rd_addr;
  logic                       wr_en;
  logic [ADDR_W-1:0]          wr_addr;
  logic [DATA_W-1:0]          wr_data;
  logic                       byte_done;
  logic [ADDR_W-1:0]          cur_addr;
  logic [NUM_REGS*DATA_W-1:0] reg_image;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_i   (spi_sclk),
    .csb_i    (spi_csb),
    .mosi_i   (spi_mosi),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .csb_s    (csb_s),
    .mosi_s   (mosi_s)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .csb_s    (csb_s),
    .mosi_s   (mosi_s),
    .ascend   (ascend),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .byte_done(byte_done),
    .cur_addr (cur_addr),
    .miso     (spi_miso)
  );

  spi_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ascend   (ascend),
    .reg_image(reg_image)
  );
endmodule

// File: rtl/spi_stream_regs_chk.sv
module spi_stream_regs_chk #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csb_s,
  input logic                       miso,
  input logic                       byte_done,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [ADDR_W-1:0]          cur_addr,
  input logic                       ascend,
  input logic [NUM_REGS*DATA_W-1:0] reg_image
);
  AST_STEP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (cur_addr == ($past(ascend) ? $past(cur_addr) + ADDR_W'(1)
                                              : $past(cur_addr) - ADDR_W'(1)))); // R6

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ascend && (cur_addr == '1)) |=> (cur_addr == '0)); // R7

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !csb_s); // R8

  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == '0)) |=> (ascend == ($past(wr_data[5]) | $past(wr_data[2])))); // R9

  AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == '0) && (wr_data[7] || wr_data[0]))
      |=> (reg_image[NUM_REGS*DATA_W-1:DATA_W] == '0)); // R10

  AST_OOR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= ADDR_W'(NUM_REGS))) |=> $stable(reg_image)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (csb_s && $past(csb_s)) |-> !miso); // R12
endmodule

bind spi_stream_regs spi_stream_regs_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csb_s    (csb_s),
  .miso     (spi_miso),
  .byte_done(byte_done),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .cur_addr (cur_addr),
  .ascend   (ascend),
  .reg_image(reg_image)
);

// File: tb/test_spi_stream_regs.sv
module test_spi_stream_regs;
  localparam int HALF = 8;
  localparam int NVEC = 8;
  // {address[14:0], write data[7:0], expected read[7:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {15'd3,      8'h11, 8'h11},  // R1 R2
    {15'd31,     8'hC3, 8'hC3},  // R1 top register
    {15'd32,     8'h77, 8'h00},  // R11
    {15'h7FFF,   8'h12, 8'h00},  // R11
    {15'd0,      8'h20, 8'h24},  // R9
    {15'd0,      8'h04, 8'h24},  // R9
    {15'd0,      8'h6A, 8'h6E},  // R9
    {15'd0,      8'h00, 8'h00}   // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0;
  logic spi_csb = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  spi_stream_regs i_spi_stream_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_sclk(spi_sclk),
    .spi_csb (spi_csb),
    .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_mosi = b;
    wait_clk(HALF);
    r = spi_miso;
    spi_sclk = 1'b1;
    wait_clk(HALF);
    spi_sclk = 1'b0;
  endtask

  task automatic frame_begin(input logic rw, input logic [14:0] addr);
    logic [15:0] hdr;
    logic dummy;
    hdr = {rw, addr};
    spi_csb = 1'b0;
    wait_clk(HALF);
    for (int i = 15; i >= 0; i--) spi_bit(hdr[i], dummy);
  endtask

  task automatic xfer_byte(input logic [7:0] w, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(w[i], r[i]);
  endtask

  task automatic xfer_bits(input int n);
    logic dummy;
    for (int i = 0; i < n; i++) spi_bit(1'b1, dummy);
  endtask

  task automatic frame_end();
    wait_clk(HALF);
    spi_csb = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic write1(input logic [14:0] addr, input logic [7:0] d);
    logic [7:0] r;
    frame_begin(1'b0, addr);
    xfer_byte(d, r);
    frame_end();
  endtask

  task automatic read1(input logic [14:0] addr, output logic [7:0] d);
    frame_begin(1'b1, addr);
    xfer_byte(8'h00, d);
    frame_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R12: reset state
    check("R12 idle miso", {7'd0, spi_miso}, 8'h00);
    read1(15'd5, r);
    check("R12 reset value reg5", r, 8'h00);
    read1(15'd0, r);
    check("R12 reset value reg0", r, 8'h00);

    // R1 R2 R9 R11: vector table
    for (int v = 0; v < NVEC; v++) begin
      write1(VEC[v][30:16], VEC[v][15:8]);
      read1(VEC[v][30:16], r);
      check($sformatf("R1/R2/R9/R11 vector %0d", v), r, VEC[v][7:0]);
    end

    // R3: independent frames separated by CSB high
    write1(15'd20, 8'h5C);
    write1(15'd21, 8'h3D);
    read1(15'd20, r);
    check("R3 first frame kept", r, 8'h5C);
    read1(15'd21, r);
    check("R3 second frame header", r, 8'h3D);

    // R4 R6: ascending streaming write
    write1(15'd0, 8'h20);
    frame_begin(1'b0, 15'd4);
    xfer_byte(8'hA1, r);
    xfer_byte(8'hA2, r);
    xfer_byte(8'hA3, r);
    frame_end();
    read1(15'd4, r); check("R4 burst reg4", r, 8'hA1);
    read1(15'd5, r); check("R4 R6 burst reg5", r, 8'hA2);
    read1(15'd6, r); check("R4 R6 burst reg6", r, 8'hA3);

    // R5: ascending streaming read
    frame_begin(1'b1, 15'd4);
    xfer_byte(8'h00, r); check("R5 stream read 0", r, 8'hA1);
    xfer_byte(8'h00, r); check("R5 stream read 1", r, 8'hA2);
    xfer_byte(8'h00, r); check("R5 stream read 2", r, 8'hA3);
    frame_end();

    // R6: descending direction
    write1(15'd0, 8'h00);
    frame_begin(1'b0, 15'd12);
    xfer_byte(8'hB1, r);
    xfer_byte(8'hB2, r);
    frame_end();
    read1(15'd11, r); check("R6 descending write", r, 8'hB2);
    frame_begin(1'b1, 15'd12);
    xfer_byte(8'h00, r); check("R6 descending read 0", r, 8'hB1);
    xfer_byte(8'h00, r); check("R6 descending read 1", r, 8'hB2);
    frame_end();

    // R7: ascending wrap from 0x7FFF to 0x0000
    write1(15'd0, 8'h20);
    frame_begin(1'b0, 15'h7FFF);
    xfer_byte(8'h99, r);
    xfer_byte(8'h24, r);
    xfer_byte(8'h5A, r);
    frame_end();
    read1(15'd1, r); check("R7 wrap reached reg1", r, 8'h5A);
    read1(15'd0, r); check("R7 wrap reached reg0", r, 8'h24);

    // R8: partial bytes discarded
    write1(15'd6, 8'h33);
    write1(15'd8, 8'h81);
    frame_begin(1'b0, 15'd6);
    xfer_bits(5);
    frame_end();
    read1(15'd6, r); check("R8 partial first byte", r, 8'h33);
    frame_begin(1'b0, 15'd7);
    xfer_byte(8'h44, r);
    xfer_bits(3);
    frame_end();
    read1(15'd7, r); check("R8 full byte kept", r, 8'h44);
    read1(15'd8, r); check("R8 partial stream byte", r, 8'h81);

    // R10: soft reset via bit 7, then via bit 0
    write1(15'd0, 8'hA4);
    read1(15'd0, r); check("R10 reg0 after bit7", r, 8'h24);
    read1(15'd4, r); check("R10 reg4 cleared", r, 8'h00);
    read1(15'd7, r); check("R10 reg7 cleared", r, 8'h00);
    write1(15'd9, 8'h66);
    write1(15'd0, 8'h01);
    read1(15'd0, r); check("R10 reg0 after bit0", r, 8'h00);
    read1(15'd9, r); check("R10 reg9 cleared", r, 8'h00);

    check("R12 idle miso end", {7'd0, spi_miso}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule